// File: doc/BRIEF.md
# Serial Receiver with Per-Character Status

This block receives asynchronous serial characters from a single input line and places them in a two-entry receive buffer. It oversamples the line with an external baud tick, checks the start bit again at mid-bit, collects 5 to 9 data bits least-significant first, and can check an even or odd parity bit. Each stored character keeps its own frame-error, parity-error and overrun marks. These marks move through the buffer with the character, so software always sees the marks of the character it is about to read.

Software uses a four-location register port. One location holds the data and is popped by reading it. One holds status and the speed and filter mode bits. One holds control: interrupt enable, receiver enable, parity mode and character size. The last one shows the ninth data bit of the head character. A filter mode keeps only characters whose ninth bit is set, so that address frames can be picked out. An interrupt line is raised while a character is waiting, the local enable is set and the global enable input is high.

Top module: `serial_rx_unit`

## Requirements
- R1: After reset, the status (address 1), control (address 2) and ninth-bit (address 3) locations read 0x00, and irqRx is low.
- R2: A character is received least-significant bit first. Status bit 7 is 1 while the buffer holds an unread character. Reading address 0 returns data bits 7:0 of the head character and removes that character.
- R3: Status bit 4 (frame error) of a character is 1 when the stop bit sampled for it is 0, and 0 when that stop bit is 1.
- R4: Control bits 5:4 select parity: 0x = none, 10 = even, 11 = odd. Status bit 2 (parity error) is set only when parity checking was on while the character was received and the received parity bit does not match. Turning parity off afterwards does not clear the mark.
- R5: Status bit 3 (overrun) is set only when three conditions hold together: both buffer entries are full, a completed character waits in the shift stage, and a new start bit is qualified. The waiting character is kept and carries the mark. The incoming character is lost.
- R6: The three error marks shown in status belong to the head character and change only when it is read.
- R7: Control bits 3:0 set the size code. A code c from 0 to 3 gives 5+c data bits, and a code of 4 or more gives 9 bits. Address 3 bit 0 shows the head character's ninth bit. Unused upper data bits read 0.
- R8: Status bit 1 selects 8 samples per bit instead of 16.
- R9: When status bit 0 is set, a frame whose ninth data bit is 0 is dropped without storage or marks. Frames with fewer than 9 data bits are dropped too, because they have no ninth bit.
- R10: irqRx equals control bit 7 AND gie AND status bit 7.
- R11: A write to status changes only bits 1:0. The error marks keep their values whatever is written to bits 4:2.
- R12: A low pulse on the line that has ended by the mid-bit sample of the start bit is rejected as a glitch and stores nothing.
- R13: Two characters can be held unread at once without loss and without an overrun mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxLine | input | 1 | Serial input line, idle high |
| baudTick | input | 1 | One-cycle oversample enable |
| regAddr | input | 2 | Register address (0 data, 1 status, 2 control, 3 ninth bit) |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdEn | input | 1 | Register read strobe; a read of address 0 pops |
| regRdData | output | 8 | Register read data (combinational from regAddr) |
| gie | input | 1 | Global interrupt enable |
| irqRx | output | 1 | Receive interrupt request |

## Verification
The line passes through a two-stage synchronizer. A start is then seen on the next baud tick, and every later sample falls near mid-bit. A character is therefore committed at the middle of its stop bit and shows in the status in the cycle that follows. For that reason the checks read registers only after two idle bit periods that follow each frame. Register reads are combinational, so they are sampled one time unit after the falling edge on which the address is set, and a pop takes effect at the next rising edge. The irqRx output follows its enables in the same cycle and is sampled the same way.

// File: rtl/serial_rx_pkg.sv
`timescale 1ns/1ps
package serial_rx_pkg;
  localparam int unsigned DATA_W = 9;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
  localparam logic [1:0] ADDR_NINE = 2'd3;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
  } rxState_e;

  typedef struct packed {
    logic       startSeen;
    logic       startOk;
    logic       takeData;
    logic       takePar;
    logic       takeStop;
    logic [3:0] bitIdx;
  } rxStrobe_t;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              frameErr;
    logic              parErr;
    logic              overrun;
  } rxEntry_t;
endpackage

// File: rtl/serial_rx_ctrl.sv
`timescale 1ns/1ps
module serial_rx_ctrl
  import serial_rx_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      baudTick,
  input  logic      rxIn,
  input  logic      rxEn,
  input  logic      cfgDbl,
  input  logic [3:0] cfgBits,
  input  logic      cfgPar,
  output rxStrobe_t strobe
);
  localparam int unsigned CNT_W = $clog2(OSR);

  rxState_e         state;
  logic [CNT_W-1:0] tickCnt;
  logic [3:0]       bitIdx;
  logic [CNT_W-1:0] fullEnd, halfEnd;
  logic             atFull, atHalf;

  assign fullEnd = cfgDbl ? CNT_W'(OSR/2 - 1) : CNT_W'(OSR - 1);
  assign halfEnd = cfgDbl ? CNT_W'(OSR/4 - 1) : CNT_W'(OSR/2 - 1);
  assign atFull  = baudTick && (tickCnt == fullEnd);
  assign atHalf  = baudTick && (tickCnt == halfEnd);

  always_comb begin
    strobe = '0;
    strobe.bitIdx = bitIdx;
    unique case (state)
      RX_IDLE:  strobe.startSeen = rxEn && baudTick && !rxIn;
      RX_START: strobe.startOk   = atHalf && !rxIn;
      RX_DATA:  strobe.takeData  = atFull;
      RX_PAR:   strobe.takePar   = atFull;
      RX_STOP:  strobe.takeStop  = atFull;
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= RX_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else begin
      unique case (state)
        RX_IDLE: if (strobe.startSeen) begin
          state   <= RX_START;
          tickCnt <= '0;
        end
        RX_START: if (baudTick) begin
          if (atHalf) begin
            tickCnt <= '0;
            bitIdx  <= '0;
            state   <= rxIn ? RX_IDLE : RX_DATA;
          end else tickCnt <= tickCnt + CNT_W'(1);
        end
        RX_DATA: if (baudTick) begin
          if (atFull) begin
            tickCnt <= '0;
            if (bitIdx == cfgBits - 4'd1) state <= cfgPar ? RX_PAR : RX_STOP;
            else bitIdx <= bitIdx + 4'd1;
          end else tickCnt <= tickCnt + CNT_W'(1);
        end
        RX_PAR: if (baudTick) begin
          if (atFull) begin
            tickCnt <= '0;
            state   <= RX_STOP;
          end else tickCnt <= tickCnt + CNT_W'(1);
        end
        RX_STOP: if (baudTick) begin
          if (atFull) begin
            tickCnt <= '0;
            state   <= RX_IDLE;
          end else tickCnt <= tickCnt + CNT_W'(1);
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_rx_dp.sv
`timescale 1ns/1ps
module serial_rx_dp
  import serial_rx_pkg::*;
#(
  parameter int unsigned DEPTH       = 2,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxLine,
  input  rxStrobe_t        strobe,
  input  logic             dblReq,
  input  logic [3:0]       sizeCode,
  input  logic [1:0]       parMode,
  input  logic             filtEn,
  input  logic             popReq,
  output logic             rxIn,
  output logic             latDbl,
  output logic [3:0]       latBits,
  output logic             latParEn,
  output logic [CNT_W-1:0] bufCount,
  output logic             holdValid,
  output rxEntry_t         head
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic [DATA_W-1:0]      shiftReg;
  logic                   parBit, latParOdd, dropCur;
  rxEntry_t               newEntry, holdEntry, pushEntry;
  rxEntry_t               slots [DEPTH];
  logic [PTR_W-1:0]       rdPtr, wrPtr;
  logic                   keep, doPop, space, pushHold, pushNew, toHold, doPush;

  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], rxLine};
  end
  assign rxIn = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latDbl    <= 1'b0;
      latBits   <= 4'd5;
      latParEn  <= 1'b0;
      latParOdd <= 1'b0;
      shiftReg  <= '0;
      parBit    <= 1'b0;
      dropCur   <= 1'b0;
    end else begin
      if (strobe.startSeen) begin
        latDbl    <= dblReq;
        latBits   <= (sizeCode >= 4'd4) ? 4'd9 : 4'd5 + sizeCode;
        latParEn  <= parMode[1];
        latParOdd <= parMode[0];
        shiftReg  <= '0;
        parBit    <= 1'b0;
        dropCur   <= 1'b0;
      end
      if (strobe.startOk && holdValid && !space) dropCur <= 1'b1;
      if (strobe.takeData)
        for (int i = 0; i < DATA_W; i++)
          if (strobe.bitIdx == 4'(i)) shiftReg[i] <= rxIn;
      if (strobe.takePar) parBit <= rxIn;
    end
  end

  always_comb begin
    newEntry          = '0;
    newEntry.data     = shiftReg;
    newEntry.frameErr = !rxIn;
    newEntry.parErr   = latParEn && (parBit != ((^shiftReg) ^ latParOdd));
    keep     = strobe.takeStop && !dropCur && !(filtEn && !shiftReg[DATA_W-1]);
    doPop    = popReq && (bufCount != '0);
    space    = (bufCount != CNT_W'(DEPTH)) || doPop;
    pushHold = holdValid && space;
    pushNew  = keep && !holdValid && space;
    toHold   = keep && !holdValid && !space;
    doPush   = pushHold || pushNew;
    pushEntry = pushHold ? holdEntry : newEntry;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdValid <= 1'b0;
      holdEntry <= '0;
    end else begin
      if (pushHold) holdValid <= 1'b0;
      else if (toHold) begin
        holdValid <= 1'b1;
        holdEntry <= newEntry;
      end
      if (strobe.startOk && holdValid && !space) holdEntry.overrun <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr    <= '0;
      wrPtr    <= '0;
      bufCount <= '0;
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
    end else begin
      if (doPush) begin
        slots[wrPtr] <= pushEntry;
        wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + PTR_W'(1);
      end
      if (doPop) rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + PTR_W'(1);
      case ({doPush, doPop})
        2'b10:   bufCount <= bufCount + CNT_W'(1);
        2'b01:   bufCount <= bufCount - CNT_W'(1);
        default: ;
      endcase
    end
  end

  assign head = (bufCount != '0) ? slots[rdPtr] : '0;
endmodule

// File: rtl/serial_rx_regs.sv
`timescale 1ns/1ps
module serial_rx_regs
  import serial_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] regAddr,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  input  logic       regRdEn,
  input  logic       gie,
  input  logic       headValid,
  input  rxEntry_t   head,
  output logic [7:0] regRdData,
  output logic       popReq,
  output logic       irqRx,
  output logic       rxEn,
  output logic       dblReq,
  output logic       filtEn,
  output logic [3:0] sizeCode,
  output logic [1:0] parMode
);
  logic irqEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqEn    <= 1'b0;
      rxEn     <= 1'b0;
      dblReq   <= 1'b0;
      filtEn   <= 1'b0;
      sizeCode <= '0;
      parMode  <= '0;
    end else if (regWrEn) begin
      if (regAddr == ADDR_STAT) begin
        dblReq <= regWrData[1];
        filtEn <= regWrData[0];
      end
      if (regAddr == ADDR_CTRL) begin
        irqEn    <= regWrData[7];
        rxEn     <= regWrData[6];
        parMode  <= regWrData[5:4];
        sizeCode <= regWrData[3:0];
      end
    end
  end

  always_comb begin
    unique case (regAddr)
      ADDR_DATA: regRdData = head.data[7:0];
      ADDR_STAT: regRdData = {headValid, 2'b00, head.frameErr, head.overrun,
                              head.parErr, dblReq, filtEn};
      ADDR_CTRL: regRdData = {irqEn, rxEn, parMode, sizeCode};
      default:   regRdData = {7'd0, head.data[DATA_W-1]};
    endcase
  end

  assign popReq = regRdEn && (regAddr == ADDR_DATA);
  assign irqRx  = irqEn && gie && headValid;
endmodule

// File: rtl/serial_rx_unit.sv
`timescale 1ns/1ps
module serial_rx_unit
  import serial_rx_pkg::*;
#(
  parameter int unsigned DEPTH       = 2,
  parameter int unsigned OSR         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxLine,
  input  logic       baudTick,
  input  logic [1:0] regAddr,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  input  logic       regRdEn,
  output logic [7:0] regRdData,
  input  logic       gie,
  output logic       irqRx
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  rxStrobe_t        strobe;
  rxEntry_t         head;
  logic             rxIn, rxEn, dblReq, filtEn, popReq, holdValid;
  logic             latDbl, latParEn;
  logic [3:0]       latBits, sizeCode;
  logic [1:0]       parMode;
  logic [CNT_W-1:0] bufCount;

  serial_rx_ctrl #(.OSR(OSR)) i_ctrl (
    .clk, .rstN, .baudTick, .rxIn, .rxEn,
    .cfgDbl(latDbl), .cfgBits(latBits), .cfgPar(latParEn), .strobe
  );

  serial_rx_dp #(.DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk, .rstN, .rxLine, .strobe, .dblReq, .sizeCode, .parMode, .filtEn,
    .popReq, .rxIn, .latDbl, .latBits, .latParEn, .bufCount, .holdValid, .head
  );

  serial_rx_regs i_regs (
    .clk, .rstN, .regAddr, .regWrEn, .regWrData, .regRdEn, .gie,
    .headValid(bufCount != '0), .head, .regRdData, .popReq, .irqRx,
    .rxEn, .dblReq, .filtEn, .sizeCode, .parMode
  );
endmodule

// File: rtl/serial_rx_checks.sv
`timescale 1ns/1ps
module serial_rx_checks
  import serial_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 2,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             gie,
  input logic             irqRx,
  input logic [1:0]       regAddr,
  input logic             regWrEn,
  input logic             regRdEn,
  input rxStrobe_t        strobe,
  input logic [CNT_W-1:0] bufCount,
  input logic             holdValid,
  input rxEntry_t         head
);
  a_r10_irq_needs_gie: assert property (@(posedge clk) disable iff (!rstN)
    !gie |-> !irqRx);
  a_r10_irq_needs_char: assert property (@(posedge clk) disable iff (!rstN)
    irqRx |-> bufCount != '0);
  a_r13_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    bufCount <= CNT_W'(DEPTH));
  a_r5_hold_only_when_full: assert property (@(posedge clk) disable iff (!rstN)
    holdValid |-> bufCount == CNT_W'(DEPTH));
  a_r2_read_pops: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == ADDR_DATA && bufCount != '0 && !holdValid && !strobe.takeStop)
    |=> bufCount == $past(bufCount) - CNT_W'(1));
  a_r11_write_keeps_head: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_STAT && !regRdEn && bufCount != '0) |=> $stable(head));
  a_r12_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.startSeen, strobe.startOk, strobe.takeData, strobe.takePar, strobe.takeStop}));
endmodule

bind serial_rx_unit serial_rx_checks #(.DEPTH(DEPTH)) i_checks (
  .clk(clk), .rstN(rstN), .gie(gie), .irqRx(irqRx), .regAddr(regAddr),
  .regWrEn(regWrEn), .regRdEn(regRdEn), .strobe(strobe), .bufCount(bufCount),
  .holdValid(holdValid), .head(head)
);

// File: tb/test_serial_rx_unit.sv
`timescale 1ns/1ps
module test_serial_rx_unit;
  logic       clk = 1'b0, rstN = 1'b0, rxLine = 1'b1, baudTick = 1'b0;
  logic       regWrEn = 1'b0, regRdEn = 1'b0, gie = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic       irqRx;
  int errors = 0, checks = 0, bitClk = 32;
  bit finished = 1'b0;

  serial_rx_unit i_serial_rx_unit (
    .clk, .rstN, .rxLine, .baudTick, .regAddr, .regWrEn, .regWrData,
    .regRdEn, .regRdData, .gie, .irqRx
  );

  initial forever #2 clk = ~clk;
  initial forever begin @(negedge clk); baudTick = ~baudTick; end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); regAddr = a; regRdEn = 1'b1; #1 d = regRdData;
    @(negedge clk); regRdEn = 1'b0;
  endtask

  task automatic expectReg(input string tag, input logic [1:0] a, input logic [7:0] exp);
    logic [7:0] v;
    readReg(a, v);
    check(tag, v, exp);
  endtask

  task automatic driveBit(input logic v, input int n);
    @(negedge clk); rxLine = v;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [8:0] d, input int nBits, input bit parOn,
                           input bit parOdd, input bit parFlip, input bit stopOk);
    logic pb = 1'b0;
    for (int i = 0; i < nBits; i++) pb ^= d[i];
    pb = pb ^ parOdd ^ parFlip;
    driveBit(1'b0, bitClk);
    for (int i = 0; i < nBits; i++) driveBit(d[i], bitClk);
    if (parOn) driveBit(pb, bitClk);
    if (stopOk) driveBit(1'b1, bitClk);
    else driveBit(1'b0, bitClk * 3 / 4);
    driveBit(1'b1, bitClk * 2);
  endtask

  task automatic send8(input logic [7:0] d);
    sendFrame({1'b0, d}, 8, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic testReset();
    expectReg("R1 status after reset", 2'd1, 8'h00);
    expectReg("R1 control after reset", 2'd2, 8'h00);
    expectReg("R1 ninth bit after reset", 2'd3, 8'h00);
    #1 check("R1 irq after reset", {7'd0, irqRx}, 8'h00);
  endtask

  task automatic testBasic();
    writeReg(2'd2, 8'h43);
    send8(8'hA5);
    expectReg("R2 ready after frame", 2'd1, 8'h80);
    expectReg("R2 data A5", 2'd0, 8'hA5);
    expectReg("R2 empty after read", 2'd1, 8'h00);
    send8(8'h3C);
    expectReg("R2 data 3C", 2'd0, 8'h3C);
  endtask

  task automatic testFrameErr();
    sendFrame(9'h096, 8, 1'b0, 1'b0, 1'b0, 1'b0);
    expectReg("R3 frame error set", 2'd1, 8'h90);
    writeReg(2'd1, 8'h00);
    expectReg("R11 zero write keeps marks", 2'd1, 8'h90);
    writeReg(2'd1, 8'h1C);
    expectReg("R11 ones write keeps marks", 2'd1, 8'h90);
    expectReg("R3 data after frame error", 2'd0, 8'h96);
    expectReg("R12 low stop tail stored nothing", 2'd1, 8'h00);
    send8(8'h11);
    expectReg("R3 good stop clears mark", 2'd1, 8'h80);
    expectReg("R3 data 11", 2'd0, 8'h11);
  endtask

  task automatic testParity();
    writeReg(2'd2, 8'h63);
    sendFrame(9'h05A, 8, 1'b1, 1'b0, 1'b0, 1'b1);
    expectReg("R4 even parity ok", 2'd1, 8'h80);
    expectReg("R4 even data", 2'd0, 8'h5A);
    sendFrame(9'h05A, 8, 1'b1, 1'b0, 1'b1, 1'b1);
    expectReg("R4 even parity bad", 2'd1, 8'h84);
    expectReg("R4 even bad data", 2'd0, 8'h5A);
    writeReg(2'd2, 8'h73);
    sendFrame(9'h007, 8, 1'b1, 1'b1, 1'b0, 1'b1);
    expectReg("R4 odd parity ok", 2'd1, 8'h80);
    expectReg("R4 odd data", 2'd0, 8'h07);
    sendFrame(9'h007, 8, 1'b1, 1'b1, 1'b1, 1'b1);
    expectReg("R4 odd parity bad", 2'd1, 8'h84);
    expectReg("R4 odd bad data", 2'd0, 8'h07);
    writeReg(2'd2, 8'h63);
    sendFrame(9'h021, 8, 1'b1, 1'b0, 1'b1, 1'b1);
    writeReg(2'd2, 8'h43);
    expectReg("R4 mark kept after parity off", 2'd1, 8'h84);
    expectReg("R4 data 21", 2'd0, 8'h21);
  endtask

  task automatic testSizes();
    writeReg(2'd2, 8'h40);
    sendFrame(9'h015, 5, 1'b0, 1'b0, 1'b0, 1'b1);
    expectReg("R7 five bit data", 2'd0, 8'h15);
    writeReg(2'd2, 8'h42);
    sendFrame(9'h06B, 7, 1'b0, 1'b0, 1'b0, 1'b1);
    expectReg("R7 seven bit data", 2'd0, 8'h6B);
    writeReg(2'd2, 8'h44);
    sendFrame(9'h1A5, 9, 1'b0, 1'b0, 1'b0, 1'b1);
    expectReg("R7 ninth bit one", 2'd3, 8'h01);
    expectReg("R7 nine bit low byte", 2'd0, 8'hA5);
    sendFrame(9'h05A, 9, 1'b0, 1'b0, 1'b0, 1'b1);
    expectReg("R7 ninth bit zero", 2'd3, 8'h00);
    expectReg("R7 nine bit low byte 2", 2'd0, 8'h5A);
  endtask

  task automatic testFilter();
    writeReg(2'd1, 8'h01);
    sendFrame(9'h0C3, 9, 1'b0, 1'b0, 1'b0, 1'b1);
    expectReg("R9 non-address frame dropped", 2'd1, 8'h01);
    sendFrame(9'h1C3, 9, 1'b0, 1'b0, 1'b0, 1'b1);
    expectReg("R9 address frame kept", 2'd1, 8'h81);
    expectReg("R9 address ninth bit", 2'd3, 8'h01);
    expectReg("R9 address data", 2'd0, 8'hC3);
    writeReg(2'd1, 8'h00);
    writeReg(2'd2, 8'h43);
  endtask

  task automatic testTwoHeld();
    send8(8'h51);
    send8(8'h52);
    expectReg("R13 first of two", 2'd1, 8'h80);
    expectReg("R13 data 51", 2'd0, 8'h51);
    expectReg("R13 second no overrun", 2'd1, 8'h80);
    expectReg("R13 data 52", 2'd0, 8'h52);
    send8(8'h61);
    send8(8'h62);
    send8(8'h63);
    expectReg("R5 three without new start", 2'd1, 8'h80);
    expectReg("R5 data 61", 2'd0, 8'h61);
    expectReg("R5 data 62", 2'd0, 8'h62);
    expectReg("R5 third not overrun", 2'd1, 8'h80);
    expectReg("R5 data 63", 2'd0, 8'h63);
  endtask

  task automatic testOverrun();
    send8(8'h41);
    send8(8'h42);
    send8(8'h43);
    send8(8'h44);
    expectReg("R6 head A clean", 2'd1, 8'h80);
    expectReg("R6 data A", 2'd0, 8'h41);
    expectReg("R6 head B clean", 2'd1, 8'h80);
    expectReg("R6 data B", 2'd0, 8'h42);
    expectReg("R5 overrun on held char", 2'd1, 8'h88);
    expectReg("R5 held char data", 2'd0, 8'h43);
    expectReg("R5 incoming char lost", 2'd1, 8'h00);
  endtask

  task automatic testDouble();
    writeReg(2'd1, 8'h02);
    bitClk = 16;
    sendFrame(9'h09E, 8, 1'b0, 1'b0, 1'b0, 1'b1);
    expectReg("R8 double speed status", 2'd1, 8'h82);
    expectReg("R8 double speed data", 2'd0, 8'h9E);
    writeReg(2'd1, 8'h00);
    bitClk = 32;
  endtask

  task automatic testIrq();
    gie = 1'b0;
    send8(8'h77);
    #1 check("R10 irq low with enables off", {7'd0, irqRx}, 8'h00);
    gie = 1'b1;
    #1 check("R10 irq low without local enable", {7'd0, irqRx}, 8'h00);
    writeReg(2'd2, 8'hC3);
    #1 check("R10 irq high", {7'd0, irqRx}, 8'h01);
    gie = 1'b0;
    #1 check("R10 irq low without gie", {7'd0, irqRx}, 8'h00);
    gie = 1'b1;
    expectReg("R10 data 77", 2'd0, 8'h77);
    #1 check("R10 irq low when empty", {7'd0, irqRx}, 8'h00);
    writeReg(2'd2, 8'h43);
  endtask

  task automatic testGlitch();
    driveBit(1'b0, 6);
    driveBit(1'b1, bitClk * 3);
    expectReg("R12 glitch stored nothing", 2'd1, 8'h00);
    send8(8'hE1);
    expectReg("R12 frame after glitch", 2'd0, 8'hE1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testBasic();
    testFrameErr();
    testParity();
    testSizes();
    testFilter();
    testTwoHeld();
    testOverrun();
    testDouble();
    testIrq();
    testGlitch();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule